// File: doc/BRIEF.md
# Telephone Linefeed State Controller

The block selects the operating state of one subscriber line interface and turns it into digital lead-control signals. The host requests one of eight line states through a 3-bit code. The controller drives the tip and ring drive enables, the high-impedance selects, the ringing generator enable, the audio path enable and a polarity flag. Analog drive, DC feed shaping and temperature sensing are outside the block. Faults reach it as digital comparator flags: one overpower flag and two thermal flags, one per shutdown threshold.

Faults take priority over the host. Overpower, or a thermal comparator above the limit that applies in the present state, returns the line to Open on the next clock. The same event sets a sticky alarm flag. Each flag can be masked from the interrupt output, but the mask never blocks the fall back to Open. Reversing polarity moves an 8-bit drive level from one end of its range to the other. A host divider sets the number of clocks per unit step, and a divider of zero flips the level in a single clock.

States and transitions: `LS_OPEN` (0), `LS_FWD_ACT` (1), `LS_REV_ACT` (2), `LS_FWD_OHT` (3), `LS_REV_OHT` (4), `LS_TIP_OPEN` (5), `LS_RING_OPEN` (6), `LS_RINGING` (7). The transitions are:
- *host load*: any state to the requested state, when no fault is present.
- *fault return*: any state to `LS_OPEN`, on overpower or on the thermal limit that applies.
- *hold*: no request and no fault, so the state is kept.

Top module: `linefeed_ctrl`

## Requirements
- R1: After reset, line_state is 0 (Open), both high-impedance selects are 1, all drive, ringing and audio enables are 0, reverse is 0, alarms are 0, irq is 0, drive_level is 255 and ramp_busy is 0.
- R2: When req_valid is 1 and no fault is present, line_state takes the value of req_code at the next clock edge. The codes are: 0 Open, 1 forward active, 2 reverse active, 3 forward on-hook transmission, 4 reverse on-hook transmission, 5 tip open, 6 ring open, 7 ringing.
- R3: In codes 1 to 4, tip_drv_en and ring_drv_en are 1, both high-impedance selects are 0, audio_en is 1 and ring_gen_en is 0. reverse is 0 for codes 1 and 3, and 1 for codes 2 and 4.
- R4: In code 5, tip_hiz is 1, tip_drv_en is 0, ring_drv_en is 1, ring_hiz is 0 and reverse is 0. Code 6 is the mirror image (ring_hiz 1, ring_drv_en 0, tip_drv_en 1, tip_hiz 0) with reverse 1. In both codes audio_en and ring_gen_en are 0.
- R5: In code 7, both leads are driven and ring_gen_en is 1, with audio_en 0. In code 0, both high-impedance selects are 1 and every drive, ringing and audio enable is 0.
- R6: If pwr_fault is 1 at a clock edge, line_state is 0 after that edge and alarms bit 0 (power) is 1.
- R7: irq equals the OR of alarms[i] AND NOT irq_mask[i]. A masked alarm still forces the Open state.
- R8: In code 7 only therm_hi (200 C comparator) causes a thermal trip. In every other state only therm_lo (145 C comparator) does. A trip forces line_state 0 and sets alarms bit 1 (thermal).
- R9: A host request at an edge where a fault is present is ignored, and line_state becomes or stays 0.
- R10: Alarm bits stay set until alarm_clr is 1 with a 1 in the matching alarm_clr_bits position. A fault at the same edge wins over the clear.
- R11: When ramp_div is 0, drive_level reaches its target one clock edge after line_state changes. The target is 255 when reverse is 0 and 0 when reverse is 1.
- R12: When ramp_div is N > 0, drive_level moves one unit toward its target every N clocks, counted from the edge at which line_state changed. ramp_busy is 1 exactly while drive_level differs from the target.
- R13: reverse reflects the present line_state without delay, and is 1 only for codes 2, 4 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host state request strobe |
| req_code | input | 3 | Requested line state code |
| ramp_div | input | DIV_W | Clocks per polarity ramp step, 0 for instant |
| pwr_fault | input | 1 | Overpower comparator flag |
| therm_lo | input | 1 | 145 C thermal comparator flag |
| therm_hi | input | 1 | 200 C thermal comparator flag |
| irq_mask | input | 2 | Interrupt mask per alarm (1 = masked) |
| alarm_clr | input | 1 | Alarm clear strobe |
| alarm_clr_bits | input | 2 | Alarm bits to clear, write-one |
| line_state | output | 3 | Present line state code |
| tip_drv_en | output | 1 | Tip lead drive enable |
| ring_drv_en | output | 1 | Ring lead drive enable |
| tip_hiz | output | 1 | Tip lead high-impedance select |
| ring_hiz | output | 1 | Ring lead high-impedance select |
| ring_gen_en | output | 1 | Ringing generator enable |
| audio_en | output | 1 | Audio path enable |
| reverse | output | 1 | Target polarity, 1 = ring above tip |
| drive_level | output | LEVEL_W | Polarity drive level, 255 forward, 0 reverse |
| ramp_busy | output | 1 | Polarity ramp in progress |
| alarms | output | 2 | Sticky alarms, bit 0 power, bit 1 thermal |
| irq | output | 1 | Interrupt request |

## Verification
The step-size property assumes that ramp_div is held stable while ramp_busy is 1. A change in the middle of a ramp could move the step counter past the new limit. The random stimulus therefore changes ramp_div only on cycles where the reference model shows no ramp in progress. Requests, fault flags, clears and masks are otherwise free. Any 3-bit code is legal, and faults and host writes are allowed to collide in the same cycle.

// File: rtl/lf_pkg.sv
package lf_pkg;

    typedef enum logic [2:0] {
        LS_OPEN      = 3'd0,
        LS_FWD_ACT   = 3'd1,
        LS_REV_ACT   = 3'd2,
        LS_FWD_OHT   = 3'd3,
        LS_REV_OHT   = 3'd4,
        LS_TIP_OPEN  = 3'd5,
        LS_RING_OPEN = 3'd6,
        LS_RINGING   = 3'd7
    } line_state_e;

    typedef struct packed {
        logic tip_drv;
        logic ring_drv;
        logic tip_hiz;
        logic ring_hiz;
        logic ring_gen;
        logic audio;
        logic reverse;
    } lead_ctrl_t;

    localparam int ALARM_PWR   = 0;
    localparam int ALARM_THERM = 1;
    localparam int NUM_ALARMS  = 2;

endpackage

// File: rtl/lf_state_fsm.sv
module lf_state_fsm
    import lf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [2:0]  req_code,
    input  logic        pwr_fault,
    input  logic        therm_lo,
    input  logic        therm_hi,
    output line_state_e state_q,
    output lead_ctrl_t  ctrl,
    output logic        pwr_trip,
    output logic        therm_trip
);

    line_state_e state_d;
    logic        any_trip;

    // The applicable thermal limit follows the present state.
    assign therm_trip = (state_q == LS_RINGING) ? therm_hi : therm_lo;
    assign pwr_trip   = pwr_fault;
    assign any_trip   = pwr_trip | therm_trip;

    always_comb begin
        state_d = state_q;
        if (any_trip) begin
            state_d = LS_OPEN;                 // fault return
        end else if (req_valid) begin
            state_d = line_state_e'(req_code); // host load
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ctrl = '0;
        unique case (state_q)
            LS_OPEN: begin
                ctrl.tip_hiz  = 1'b1;
                ctrl.ring_hiz = 1'b1;
            end
            LS_FWD_ACT, LS_FWD_OHT: begin
                ctrl.tip_drv  = 1'b1;
                ctrl.ring_drv = 1'b1;
                ctrl.audio    = 1'b1;
            end
            LS_REV_ACT, LS_REV_OHT: begin
                ctrl.tip_drv  = 1'b1;
                ctrl.ring_drv = 1'b1;
                ctrl.audio    = 1'b1;
                ctrl.reverse  = 1'b1;
            end
            LS_TIP_OPEN: begin
                ctrl.tip_hiz  = 1'b1;
                ctrl.ring_drv = 1'b1;
            end
            LS_RING_OPEN: begin
                ctrl.ring_hiz = 1'b1;
                ctrl.tip_drv  = 1'b1;
                ctrl.reverse  = 1'b1;
            end
            LS_RINGING: begin
                ctrl.tip_drv  = 1'b1;
                ctrl.ring_drv = 1'b1;
                ctrl.ring_gen = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/lf_alarm_flags.sv
module lf_alarm_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flags,
    output logic         irq
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (set_vec[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_wr && clr_bits[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

    assign irq = |(flags & ~mask);

endmodule

// File: rtl/lf_polarity_ramp.sv
module lf_polarity_ramp #(
    parameter int LEVEL_W = 8,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reverse,
    input  logic [DIV_W-1:0]   step_div,
    output logic [LEVEL_W-1:0] level,
    output logic               busy
);

    localparam logic [LEVEL_W-1:0] FWD_LEVEL = '1;
    localparam logic [LEVEL_W-1:0] REV_LEVEL = '0;

    logic [LEVEL_W-1:0] target;
    logic [DIV_W-1:0]   cnt;

    assign target = reverse ? REV_LEVEL : FWD_LEVEL;
    assign busy   = (level != target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= FWD_LEVEL;
            cnt   <= '0;
        end else if (!busy) begin
            cnt <= '0;
        end else if (step_div == '0) begin
            level <= target;
            cnt   <= '0;
        end else if (cnt == step_div - DIV_W'(1)) begin
            cnt   <= '0;
            level <= reverse ? level - LEVEL_W'(1) : level + LEVEL_W'(1);
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/linefeed_ctrl.sv
module linefeed_ctrl
    import lf_pkg::*;
#(
    parameter int LEVEL_W = 8,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_code,
    input  logic [DIV_W-1:0]   ramp_div,
    input  logic               pwr_fault,
    input  logic               therm_lo,
    input  logic               therm_hi,
    input  logic [1:0]         irq_mask,
    input  logic               alarm_clr,
    input  logic [1:0]         alarm_clr_bits,
    output logic [2:0]         line_state,
    output logic               tip_drv_en,
    output logic               ring_drv_en,
    output logic               tip_hiz,
    output logic               ring_hiz,
    output logic               ring_gen_en,
    output logic               audio_en,
    output logic               reverse,
    output logic [LEVEL_W-1:0] drive_level,
    output logic               ramp_busy,
    output logic [1:0]         alarms,
    output logic               irq
);

    line_state_e           state_q;
    lead_ctrl_t            ctrl;
    logic                  pwr_trip;
    logic                  therm_trip;
    logic [NUM_ALARMS-1:0] alarm_set;

    lf_state_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_code   (req_code),
        .pwr_fault  (pwr_fault),
        .therm_lo   (therm_lo),
        .therm_hi   (therm_hi),
        .state_q    (state_q),
        .ctrl       (ctrl),
        .pwr_trip   (pwr_trip),
        .therm_trip (therm_trip)
    );

    always_comb begin
        alarm_set              = '0;
        alarm_set[ALARM_PWR]   = pwr_trip;
        alarm_set[ALARM_THERM] = therm_trip;
    end

    lf_alarm_flags #(.N(NUM_ALARMS)) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (alarm_set),
        .clr_wr   (alarm_clr),
        .clr_bits (alarm_clr_bits),
        .mask     (irq_mask),
        .flags    (alarms),
        .irq      (irq)
    );

    lf_polarity_ramp #(.LEVEL_W(LEVEL_W), .DIV_W(DIV_W)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .reverse  (ctrl.reverse),
        .step_div (ramp_div),
        .level    (drive_level),
        .busy     (ramp_busy)
    );

    assign line_state  = state_q;
    assign tip_drv_en  = ctrl.tip_drv;
    assign ring_drv_en = ctrl.ring_drv;
    assign tip_hiz     = ctrl.tip_hiz;
    assign ring_hiz    = ctrl.ring_hiz;
    assign ring_gen_en = ctrl.ring_gen;
    assign audio_en    = ctrl.audio;
    assign reverse     = ctrl.reverse;

endmodule

// File: rtl/linefeed_ctrl_checker.sv
module linefeed_ctrl_checker #(
    parameter int LEVEL_W = 8,
    parameter int DIV_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [DIV_W-1:0]   ramp_div,
    input logic               pwr_fault,
    input logic               therm_lo,
    input logic               therm_hi,
    input logic [1:0]         irq_mask,
    input logic               alarm_clr,
    input logic [1:0]         alarm_clr_bits,
    input logic [2:0]         line_state,
    input logic               tip_hiz,
    input logic               ring_hiz,
    input logic               audio_en,
    input logic [LEVEL_W-1:0] drive_level,
    input logic [1:0]         alarms,
    input logic               irq
);

    p_fault_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fault |=> (line_state == 3'd0) && alarms[0]);

    p_open_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 3'd0) |-> tip_hiz && ring_hiz && !audio_en);

    p_ring_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 3'd7 && !therm_hi && !pwr_fault && !req_valid)
            |=> (line_state == 3'd7));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alarms[1] && !(alarm_clr && alarm_clr_bits[1])) |=> alarms[1]);

    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == 2'b11) |-> !irq);

    p_unit_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_div != '0 && $stable(ramp_div)) |->
            (drive_level == $past(drive_level)) ||
            (drive_level == $past(drive_level) + LEVEL_W'(1)) ||
            (drive_level == $past(drive_level) - LEVEL_W'(1)));

    p_therm_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_lo && line_state != 3'd7) |=> alarms[1]);

endmodule

bind linefeed_ctrl linefeed_ctrl_checker #(.LEVEL_W(LEVEL_W), .DIV_W(DIV_W)) i_linefeed_ctrl_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .ramp_div       (ramp_div),
    .pwr_fault      (pwr_fault),
    .therm_lo       (therm_lo),
    .therm_hi       (therm_hi),
    .irq_mask       (irq_mask),
    .alarm_clr      (alarm_clr),
    .alarm_clr_bits (alarm_clr_bits),
    .line_state     (line_state),
    .tip_hiz        (tip_hiz),
    .ring_hiz       (ring_hiz),
    .audio_en       (audio_en),
    .drive_level    (drive_level),
    .alarms         (alarms),
    .irq            (irq)
);

// File: tb/test_linefeed_ctrl.sv
module test_linefeed_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [2:0]    req_code;
    logic [DW-1:0] ramp_div;
    logic          pwr_fault, therm_lo, therm_hi;
    logic [1:0]    irq_mask;
    logic          alarm_clr;
    logic [1:0]    alarm_clr_bits;
    logic [2:0]    line_state;
    logic          tip_drv_en, ring_drv_en, tip_hiz, ring_hiz;
    logic          ring_gen_en, audio_en, reverse;
    logic [LW-1:0] drive_level;
    logic          ramp_busy;
    logic [1:0]    alarms;
    logic          irq;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [2:0]    m_state;
    logic [LW-1:0] m_level;
    logic [DW-1:0] m_cnt;
    logic [1:0]    m_flags;

    always #(CLK_PERIOD/2) clk = ~clk;

    linefeed_ctrl #(.LEVEL_W(LW), .DIV_W(DW)) i_linefeed_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .ramp_div(ramp_div), .pwr_fault(pwr_fault), .therm_lo(therm_lo),
        .therm_hi(therm_hi), .irq_mask(irq_mask), .alarm_clr(alarm_clr),
        .alarm_clr_bits(alarm_clr_bits), .line_state(line_state),
        .tip_drv_en(tip_drv_en), .ring_drv_en(ring_drv_en), .tip_hiz(tip_hiz),
        .ring_hiz(ring_hiz), .ring_gen_en(ring_gen_en), .audio_en(audio_en),
        .reverse(reverse), .drive_level(drive_level), .ramp_busy(ramp_busy),
        .alarms(alarms), .irq(irq)
    );

    // {tip_drv, ring_drv, tip_hiz, ring_hiz, ring_gen, audio, reverse}
    function automatic logic [6:0] exp_ctrl(input logic [2:0] s);
        case (s)
            3'd0: return 7'b0011000;
            3'd1, 3'd3: return 7'b1100010;
            3'd2, 3'd4: return 7'b1100011;
            3'd5: return 7'b0110000;
            3'd6: return 7'b1001001;
            default: return 7'b1100100;
        endcase
    endfunction

    function automatic logic [LW-1:0] exp_target(input logic [2:0] s);
        return exp_ctrl(s)[0] ? '0 : '1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_state = 3'd0; m_level = '1; m_cnt = '0; m_flags = 2'b00;
    endtask

    task automatic model_step();
        logic          tr_p, tr_t;
        logic [LW-1:0] tgt;
        logic [2:0]    ns;
        tr_p = pwr_fault;
        tr_t = (m_state == 3'd7) ? therm_hi : therm_lo;
        tgt  = exp_target(m_state);
        if (m_level == tgt) m_cnt = '0;
        else if (ramp_div == '0) begin m_level = tgt; m_cnt = '0; end
        else if (m_cnt == ramp_div - 1) begin
            m_cnt = '0;
            m_level = (tgt == '0) ? m_level - 1 : m_level + 1;
        end else m_cnt = m_cnt + 1;
        for (int i = 0; i < 2; i++) begin
            if (alarm_clr && alarm_clr_bits[i]) m_flags[i] = 1'b0;
        end
        m_flags = m_flags | {tr_t, tr_p};
        ns = m_state;
        if (tr_p || tr_t) ns = 3'd0;
        else if (req_valid) ns = req_code;
        m_state = ns;
    endtask

    task automatic compare_all();
        chk("R2 R6 R8 R9 line_state", int'(line_state), int'(m_state));
        chk("R3 R4 R5 R13 lead controls",
            int'({tip_drv_en, ring_drv_en, tip_hiz, ring_hiz, ring_gen_en, audio_en, reverse}),
            int'(exp_ctrl(m_state)));
        chk("R11 R12 drive_level", int'(drive_level), int'(m_level));
        chk("R12 ramp_busy", int'(ramp_busy), int'(m_level != exp_target(m_state)));
        chk("R10 alarms", int'(alarms), int'(m_flags));
        chk("R7 irq", int'(irq), int'(|(m_flags & ~irq_mask)));
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_code = 0; pwr_fault = 0; therm_lo = 0; therm_hi = 0;
        alarm_clr = 0; alarm_clr_bits = 0;
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        #1;
        compare_all();
    endtask

    task automatic request(input logic [2:0] code);
        req_valid = 1; req_code = code;
        cycle();
        req_valid = 0;
    endtask

    initial begin : main
        void'($urandom(32'd20240611));
        rst_n = 0; ramp_div = '0; irq_mask = 2'b00;
        idle_inputs();
        model_reset();
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 state", int'(line_state), 0);
        chk("R1 hiz", int'({tip_hiz, ring_hiz}), 3);
        chk("R1 enables", int'({tip_drv_en, ring_drv_en, ring_gen_en, audio_en, reverse}), 0);
        chk("R1 level", int'(drive_level), 255);
        chk("R1 flags irq busy", int'({alarms, irq, ramp_busy}), 0);
        rst_n = 1;
        cycle();

        // R2 R3 R4 R5 R13: visit every state code
        for (int s = 1; s < 8; s++) begin
            request(3'(s));
            chk("R2 code loaded", int'(line_state), s);
            chk("R13 reverse now", int'(reverse), int'(s == 2 || s == 4 || s == 6));
            cycle();
        end
        request(3'd0);
        chk("R5 open hiz", int'({tip_hiz, ring_hiz, audio_en}), 6);
        cycle();

        // R11 instant flip
        request(3'd1);
        cycle();
        request(3'd2);
        chk("R11 level before flip edge", int'(drive_level), 255);
        cycle();
        chk("R11 level after one edge", int'(drive_level), 0);

        // R12 divided ramp, N = 3
        ramp_div = 8'd3;
        request(3'd1);
        cycle(); cycle();
        chk("R12 no step after 2 clocks", int'(drive_level), 0);
        chk("R12 busy", int'(ramp_busy), 1);
        cycle();
        chk("R12 one step after 3 clocks", int'(drive_level), 1);
        while (m_level != exp_target(m_state)) cycle();
        chk("R12 idle at end", int'(ramp_busy), 0);
        ramp_div = '0;

        // R6 power fault
        pwr_fault = 1;
        cycle();
        pwr_fault = 0;
        chk("R6 forced open", int'(line_state), 0);
        chk("R6 power alarm", int'(alarms[0]), 1);
        chk("R7 irq unmasked", int'(irq), 1);
        irq_mask = 2'b01;
        #1;
        chk("R7 irq masked", int'(irq), 0);
        // R7 masked fault still forces open
        request(3'd3);
        pwr_fault = 1;
        cycle();
        pwr_fault = 0;
        chk("R7 masked still opens", int'(line_state), 0);

        // R9 request during fault ignored
        pwr_fault = 1; req_valid = 1; req_code = 3'd1;
        cycle();
        chk("R9 request ignored", int'(line_state), 0);
        // R10 clear with fault present: set wins
        alarm_clr = 1; alarm_clr_bits = 2'b01;
        cycle();
        chk("R10 set beats clear", int'(alarms[0]), 1);
        idle_inputs();
        alarm_clr = 1; alarm_clr_bits = 2'b01;
        cycle();
        alarm_clr = 0;
        chk("R10 cleared", int'(alarms[0]), 0);

        // R8 thermal limit depends on state
        request(3'd7);
        therm_lo = 1;
        cycle();
        chk("R8 ringing ignores 145C", int'(line_state), 7);
        therm_hi = 1;
        cycle();
        chk("R8 ringing trips at 200C", int'(line_state), 0);
        chk("R8 thermal alarm", int'(alarms[1]), 1);
        idle_inputs();
        request(3'd1);
        therm_lo = 1;
        cycle();
        chk("R8 active trips at 145C", int'(line_state), 0);
        idle_inputs();
        irq_mask = 2'b00;

        // constrained random phase
        for (int n = 0; n < 6000; n++) begin
            req_valid      = ($urandom_range(0, 99) < 30);
            req_code       = 3'($urandom_range(0, 7));
            pwr_fault      = ($urandom_range(0, 99) < 2);
            therm_lo       = ($urandom_range(0, 99) < 4);
            therm_hi       = ($urandom_range(0, 99) < 2);
            alarm_clr      = ($urandom_range(0, 99) < 8);
            alarm_clr_bits = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 99) < 3) irq_mask = 2'($urandom_range(0, 3));
            if (m_level == exp_target(m_state) && $urandom_range(0, 99) < 10)
                ramp_div = DW'($urandom_range(0, 2));
            cycle();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule